// File: doc/BRIEF.md
# Banked General Register File

This block holds the general-purpose registers of a processor core. The upper registers are a plain array. The lower eight are live registers, and each of them also has two shadow slots, one in each of two banks. A status register decides which bank is effective. In user mode, when the privilege flag is clear, bank 0 is always effective. In privileged mode the effective bank is the opposite of the bank-select flag.

Every write to the status register compares the effective bank before the write with the effective bank after it. When the two differ, the eight live low registers are stored into the shadow slots of the outgoing bank. In the same clock edge they are reloaded from the shadow slots of the incoming bank.

The core uses the block through two combinational read ports, one write port and a status write port. A separate direct port reads and writes shadow slots. It always targets the bank given by the inverse of the bank-select flag. Exception entry and instruction decode sit outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register, both shadow banks and the status register read as zero.
- R2: A write through the write port is visible on both read ports from the next cycle. A read of the register being written in the same cycle returns the old value.
- R3: The effective bank is 0 whenever status bit 30 (privilege) is 0, whatever the value of bit 29. When bit 30 is 1, the effective bank is 1 if bit 29 is 0 and 0 if bit 29 is 1.
- R4: A status write that changes the effective bank stores live registers 0 to 7 into the outgoing bank and loads them from the incoming bank. Reads in the next cycle return the incoming bank's contents.
- R5: A status write that leaves the effective bank unchanged does not alter live registers 0 to 7. This covers toggling bit 29 while bit 30 is 0, and changing bit 28.
- R6: Registers 8 and above are never affected by a bank change.
- R7: The direct port reads and writes the shadow slot in bank 1 when status bit 29 is 0, and in bank 0 when bit 29 is 1, as given by the current status. A direct write is visible on the direct read port in the next cycle.
- R8: A regular write to a low register in the same cycle as a bank-changing status write lands in the newly loaded live set.
- R9: The status output shows all 32 written bits from the cycle after a status write, and it holds when no status write occurs.
- R10: A direct write in the same cycle as a bank change takes priority over the swap's store when both target the same shadow slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_wr_en | input | 1 | Status write enable |
| sr_wr_data | input | 32 | New status value |
| sr_q | output | 32 | Current status value |
| alt_wr_en | input | 1 | Direct shadow-slot write enable |
| alt_wr_idx | input | 3 | Direct write slot index |
| alt_wr_data | input | 32 | Direct write data |
| alt_rd_idx | input | 3 | Direct read slot index |
| alt_rd_data | output | 32 | Direct read data (combinational) |

## Verification
A wrong swap decision or a misrouted swap path shows on the read ports in the cycle right after the status write, because the low registers then hold the wrong bank's values. A corrupted store into the outgoing bank stays hidden until the next swap back, or until the direct port reads that slot. For that reason the bench always swaps away and then back, and it reads through the direct port. A fault in the upper registers or in the status register appears on the next read of the affected index.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int SR_W     = 32;
  localparam int MODE_BIT = 30;  // privilege flag
  localparam int SEL_BIT  = 29;  // bank-select flag
  localparam int HOLD_BIT = 28;  // block flag, stored only

  typedef logic [SR_W-1:0] status_t;

  // Effective bank of the live low registers for a given status word.
  function automatic logic live_bank_of(status_t s);
    return s[MODE_BIT] & ~s[SEL_BIT];
  endfunction

  // Bank reached by the direct shadow port for a given status word.
  function automatic logic direct_bank_of(status_t s);
    return ~s[SEL_BIT];
  endfunction
endpackage

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sr_wr_en,
  input  status_t sr_wr_data,
  output status_t sr_q,
  output logic    cur_bank,
  output logic    nxt_bank,
  output logic    swap_evt,
  output logic    direct_bank
);
  status_t sr_r;

  always_ff @(posedge clk) begin
    if (!rst_n)        sr_r <= '0;
    else if (sr_wr_en) sr_r <= sr_wr_data;
  end

  assign sr_q        = sr_r;
  assign cur_bank    = live_bank_of(sr_r);
  assign nxt_bank    = live_bank_of(sr_wr_data);
  assign swap_evt    = sr_wr_en && (cur_bank != nxt_bank);
  assign direct_bank = direct_bank_of(sr_r);
endmodule

// File: rtl/brf_low_set.sv
module brf_low_set #(
  parameter int DATA_W      = 32,
  parameter int BANKED_REGS = 8,
  localparam int LOW_W      = $clog2(BANKED_REGS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_hit,
  input  logic [LOW_W-1:0]                      wr_sel,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  swap_evt,
  input  logic                                  cur_bank,
  input  logic                                  nxt_bank,
  input  logic                                  alt_we,
  input  logic                                  alt_bank,
  input  logic [LOW_W-1:0]                      alt_wr_idx,
  input  logic [DATA_W-1:0]                     alt_wr_data,
  input  logic [LOW_W-1:0]                      alt_rd_idx,
  output logic [BANKED_REGS-1:0][DATA_W-1:0]    live_q,
  output logic [DATA_W-1:0]                     alt_rd_data
);
  logic [BANKED_REGS-1:0][DATA_W-1:0] shadow0;
  logic [BANKED_REGS-1:0][DATA_W-1:0] shadow1;

  for (genvar g = 0; g < BANKED_REGS; g++) begin : g_ent
    logic [DATA_W-1:0] live_r, sh0_r, sh1_r;
    logic              own_wr, alt0_hit, alt1_hit;

    assign own_wr   = wr_hit && (wr_sel == LOW_W'(g));
    assign alt0_hit = alt_we && !alt_bank && (alt_wr_idx == LOW_W'(g));
    assign alt1_hit = alt_we &&  alt_bank && (alt_wr_idx == LOW_W'(g));

    // Live entry: the regular write wins over the reload from the swap.
    always_ff @(posedge clk) begin
      if (!rst_n)        live_r <= '0;
      else if (own_wr)   live_r <= wr_data;
      else if (swap_evt) live_r <= nxt_bank ? sh1_r : sh0_r;
    end

    // Shadow slots: the direct write wins over the store from the swap.
    always_ff @(posedge clk) begin
      if (!rst_n)                      sh0_r <= '0;
      else if (alt0_hit)               sh0_r <= alt_wr_data;
      else if (swap_evt && !cur_bank)  sh0_r <= live_r;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                      sh1_r <= '0;
      else if (alt1_hit)               sh1_r <= alt_wr_data;
      else if (swap_evt && cur_bank)   sh1_r <= live_r;
    end

    assign live_q[g]  = live_r;
    assign shadow0[g] = sh0_r;
    assign shadow1[g] = sh1_r;
  end

  assign alt_rd_data = alt_bank ? shadow1[alt_rd_idx] : shadow0[alt_rd_idx];
endmodule

// File: rtl/brf_high_set.sv
module brf_high_set #(
  parameter int DATA_W    = 32,
  parameter int HIGH_REGS = 8,
  localparam int HIGH_W   = (HIGH_REGS > 1) ? $clog2(HIGH_REGS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_hit,
  input  logic [HIGH_W-1:0]                  wr_sel,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [HIGH_REGS-1:0][DATA_W-1:0]   high_q
);
  for (genvar g = 0; g < HIGH_REGS; g++) begin : g_ent
    logic [DATA_W-1:0] val_r;
    always_ff @(posedge clk) begin
      if (!rst_n)                                     val_r <= '0;
      else if (wr_hit && (wr_sel == HIGH_W'(g)))      val_r <= wr_data;
    end
    assign high_q[g] = val_r;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 16,
  parameter int BANKED_REGS = 8,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int LOW_W      = $clog2(BANKED_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  output logic [SR_W-1:0]   sr_q,
  input  logic              alt_wr_en,
  input  logic [LOW_W-1:0]  alt_wr_idx,
  input  logic [DATA_W-1:0] alt_wr_data,
  input  logic [LOW_W-1:0]  alt_rd_idx,
  output logic [DATA_W-1:0] alt_rd_data
);
  localparam int HIGH_REGS = NUM_REGS - BANKED_REGS;
  localparam int HIGH_W    = (HIGH_REGS > 1) ? $clog2(HIGH_REGS) : 1;
  localparam logic [IDX_W-1:0] LOW_LIM = IDX_W'(BANKED_REGS);

  logic cur_bank, nxt_bank, swap_evt, direct_bank;
  logic [BANKED_REGS-1:0][DATA_W-1:0] live_q;
  logic [HIGH_REGS-1:0][DATA_W-1:0]   high_q;

  logic             wr_low, wr_high;
  logic [IDX_W-1:0] wr_off, a_off, b_off;

  assign wr_low  = wr_en && (wr_idx <  LOW_LIM);
  assign wr_high = wr_en && (wr_idx >= LOW_LIM);
  assign wr_off  = wr_idx   - LOW_LIM;
  assign a_off   = rd_a_idx - LOW_LIM;
  assign b_off   = rd_b_idx - LOW_LIM;

  brf_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .sr_q       (sr_q),
    .cur_bank   (cur_bank),
    .nxt_bank   (nxt_bank),
    .swap_evt   (swap_evt),
    .direct_bank(direct_bank)
  );

  brf_low_set #(
    .DATA_W     (DATA_W),
    .BANKED_REGS(BANKED_REGS)
  ) u_low (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_low),
    .wr_sel     (wr_idx[LOW_W-1:0]),
    .wr_data    (wr_data),
    .swap_evt   (swap_evt),
    .cur_bank   (cur_bank),
    .nxt_bank   (nxt_bank),
    .alt_we     (alt_wr_en),
    .alt_bank   (direct_bank),
    .alt_wr_idx (alt_wr_idx),
    .alt_wr_data(alt_wr_data),
    .alt_rd_idx (alt_rd_idx),
    .live_q     (live_q),
    .alt_rd_data(alt_rd_data)
  );

  brf_high_set #(
    .DATA_W   (DATA_W),
    .HIGH_REGS(HIGH_REGS)
  ) u_high (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_high),
    .wr_sel (wr_off[HIGH_W-1:0]),
    .wr_data(wr_data),
    .high_q (high_q)
  );

  always_comb begin
    if (rd_a_idx < LOW_LIM) rd_a_data = live_q[rd_a_idx[LOW_W-1:0]];
    else                    rd_a_data = high_q[a_off[HIGH_W-1:0]];
  end

  always_comb begin
    if (rd_b_idx < LOW_LIM) rd_b_data = live_q[rd_b_idx[LOW_W-1:0]];
    else                    rd_b_data = high_q[b_off[HIGH_W-1:0]];
  end
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 16,
  parameter int BANKED_REGS = 8,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_wr_en,
  input logic [SR_W-1:0]   sr_wr_data,
  input logic [SR_W-1:0]   sr_q,
  input logic              cur_bank,
  input logic              swap_evt,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data
);
  localparam logic [IDX_W-1:0] LOW_LIM = IDX_W'(BANKED_REGS);

  AST_SR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> sr_q == $past(sr_wr_data)); // R9

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> $stable(sr_q)); // R9

  AST_SWAP_NEEDS_SR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> sr_wr_en); // R4

  AST_SWAP_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> cur_bank != $past(cur_bank)); // R4

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> $stable(cur_bank)); // R5

  AST_USER_MODE_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_q[MODE_BIT] |-> !cur_bank); // R3

  AST_HIGH_UNSWAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_idx >= LOW_LIM) && !(wr_en && wr_idx == rd_a_idx))
    |=> (rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data))); // R6
endmodule

bind banked_regfile brf_checker #(
  .DATA_W     (DATA_W),
  .NUM_REGS   (NUM_REGS),
  .BANKED_REGS(BANKED_REGS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sr_wr_en  (sr_wr_en),
  .sr_wr_data(sr_wr_data),
  .sr_q      (sr_q),
  .cur_bank  (cur_bank),
  .swap_evt  (swap_evt),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, sr_wr_en = 1'b0, alt_wr_en = 1'b0;
  logic [31:0] sr_wr_data = '0, sr_q, alt_wr_data = '0, alt_rd_data;
  logic [2:0]  alt_wr_idx = '0, alt_rd_idx = '0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_q(sr_q),
    .alt_wr_en(alt_wr_en), .alt_wr_idx(alt_wr_idx), .alt_wr_data(alt_wr_data),
    .alt_rd_idx(alt_rd_idx), .alt_rd_data(alt_rd_data)
  );

  // Reference state kept by the bench.
  logic [31:0] m_live [8];
  logic [31:0] m_sh   [2][8];
  logic [31:0] m_hi   [8];
  logic [31:0] m_sr;

  typedef struct { string req; int port; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Bank selection written as a table lookup on {privilege, select}.
  function automatic int eff_bank(logic [31:0] s);
    case ({s[30], s[29]})
      2'b10:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int idx);
    return (idx < 8) ? m_live[idx] : m_hi[idx - 8];
  endfunction

  task automatic step(string req, bit we, int wi, logic [31:0] wd,
                      bit swe, logic [31:0] sd, bit awe, int ai, logic [31:0] ad,
                      int ra, int rb, int ar);
    item_t it;
    logic [31:0] load [8];
    int ob, nb, db;
    @(negedge clk);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sr_wr_en = swe; sr_wr_data = sd;
    alt_wr_en = awe; alt_wr_idx = 3'(ai); alt_wr_data = ad;
    rd_a_idx = 4'(ra); rd_b_idx = 4'(rb); alt_rd_idx = 3'(ar);
    db = m_sr[29] ? 0 : 1;
    it.req = req;
    it.port = 0; it.exp = model_read(ra);  sb_q.push_back(it);
    it.port = 1; it.exp = model_read(rb);  sb_q.push_back(it);
    it.port = 2; it.exp = m_sh[db][ar];    sb_q.push_back(it);
    it.port = 3; it.exp = m_sr;            sb_q.push_back(it);
    // Reference update for the coming edge.
    ob = eff_bank(m_sr);
    nb = swe ? eff_bank(sd) : ob;
    if (ob != nb) begin
      for (int i = 0; i < 8; i++) load[i] = m_sh[nb][i];
      for (int i = 0; i < 8; i++) m_sh[ob][i] = m_live[i];
      for (int i = 0; i < 8; i++) m_live[i] = load[i];
    end
    if (awe) m_sh[db][ai] = ad;
    if (we) begin
      if (wi < 8) m_live[wi] = wd;
      else        m_hi[wi - 8] = wd;
    end
    if (swe) m_sr = sd;
  endtask

  task automatic rd(string req, int ra, int rb, int ar);
    step(req, 0, 0, '0, 0, '0, 0, 0, '0, ra, rb, ar);
  endtask

  task automatic set_sr(string req, logic [31:0] sd);
    step(req, 0, 0, '0, 1, sd, 0, 0, '0, 0, 8, 0);
  endtask

  // Monitor: compares queued expectations with the ports mid-cycle.
  initial begin
    forever begin
      @(negedge clk); #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.port)
          0: act = rd_a_data;
          1: act = rd_b_data;
          2: act = alt_rd_data;
          default: act = sr_q;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s port %0d: actual %h expected %h", it.req, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_live[i] = '0; m_hi[i] = '0; m_sh[0][i] = '0; m_sh[1][i] = '0;
    end
    m_sr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd("R1", 0, 12, 3);
    rd("R1", 7, 15, 7);
    // R2: fill all registers; same-cycle read of the written index gives the old value
    for (int i = 0; i < 16; i++)
      step("R2", 1, i, 32'hA500_0000 + i * 32'h0101, 0, '0, 0, 0, '0, i, (i + 15) % 16, 0);
    for (int i = 0; i < 8; i++) rd("R2", i, i + 8, 0);
    // R7: status 0 -> direct port reaches bank 1
    for (int i = 0; i < 8; i++)
      step("R7", 0, 0, '0, 0, '0, 1, i, 32'hB100_0000 + i, 0, 8, i);
    for (int i = 0; i < 8; i++) rd("R7", i, 8, i);
    // R5: select toggled in user mode, then block flag: no bank change
    set_sr("R5", 32'h2000_0000);
    for (int i = 0; i < 8; i++)
      step("R7", 0, 0, '0, 0, '0, 1, i, 32'hC000_0000 + i, 0, 8, i);
    set_sr("R5", 32'h1000_0000);
    for (int i = 0; i < 8; i++) rd("R5", i, 7 - i, i);
    set_sr("R5", 32'h0000_0000);
    // R4: enter privileged mode with select 0 -> bank 1 swapped in
    set_sr("R4", 32'h4000_0000);
    for (int i = 0; i < 8; i++) rd("R4", i, 7 - i, i);
    for (int i = 8; i < 16; i++) rd("R6", i, 23 - i, 0);
    // R3: bit 31 change keeps bank 1; back to bank 0 via select; user mode with select keeps bank 0
    set_sr("R3", 32'hC000_0000);
    rd("R3", 3, 4, 3);
    set_sr("R4", 32'h6000_0000);
    for (int i = 0; i < 8; i++) rd("R4", i, i + 8, i);
    set_sr("R3", 32'h2000_0000);
    rd("R3", 1, 6, 1);
    // R8: write during a bank-changing status write
    step("R8", 1, 2, 32'h8888_1234, 1, 32'h4000_0000, 0, 0, '0, 2, 9, 2);
    rd("R8", 2, 3, 2);
    set_sr("R8", 32'h0000_0000);
    rd("R8", 2, 1, 2);
    set_sr("R8", 32'h4000_0000);
    rd("R8", 2, 5, 5);
    // R10: direct write collides with the swap store into bank 1 slot 5
    step("R10", 0, 0, '0, 1, 32'h0000_0000, 1, 5, 32'h1010_1010, 5, 5, 5);
    rd("R10", 5, 4, 5);
    set_sr("R10", 32'h4000_0000);
    rd("R10", 5, 4, 5);
    // R9: full-width status readback
    set_sr("R9", 32'h9ABC_DEF0);
    rd("R9", 0, 10, 0);
    set_sr("R9", 32'h5555_AAAA);
    rd("R9", 6, 11, 6);
    step("R6", 1, 12, 32'hFACE_0012, 1, 32'h0000_0001, 0, 0, '0, 12, 13, 0);
    for (int i = 0; i < 16; i++) rd("R6", i, 15 - i, i % 8);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule